// File: doc/BRIEF.md
# Page-Table Entry Accessed/Dirty Updater

This block follows a hardware page-table walker. For each walk that reached a leaf, it receives the leaf entry, the physical address the entry was read from, the access kind (load, store or instruction fetch), a huge-page flag, a probe flag, the lookup outcome, and the even/odd entry pair that is going to the TLB. It decides whether the entry still lacks the accessed bit, or the dirty bit for a store. If a bit is missing, it writes the bits back to memory with one atomic 64-bit compare-and-swap.

Another agent may change the entry between the walk and the swap. When that happens, the swap reports a mismatch. The block then re-reads the entry from the same address and runs the decision again. A bounded retry counter turns endless contention into a fault code. When the swap succeeds, the block marks the same bits in the outgoing even/odd pair: in the half the access used, and for a huge page in both halves. The block finishes with a one-cycle completion pulse that carries the final pair and a result code.

Top module: `pte_ad_updater`

## Requirements
- R1: The accessed bit is entry bit 0 and the dirty bit is entry bit 1. Access codes are load=0, store=1, fetch=2. A store whose entry already has dirty=1, or a load or fetch whose entry already has accessed=1, completes with result MATCH (code 0). It issues no memory request and returns the pair unchanged.
- R2: When the probe flag is set, or the lookup missed, or hardware walking is disabled, the block issues no memory request and returns the pair unchanged. The result is MATCH (0) if the lookup hit and NOMATCH (1) if it missed.
- R3: Otherwise the block issues a compare-and-swap to the entry's address. The compare value is the entry as last read. The swap value is that entry with bit 0 set, and with bit 1 also set for a store.
- R4: A swap status of MISMATCH (code 1) is followed by a read request to the same address. The returned word replaces the entry, and the decision of R1–R3 is taken again on it. A reloaded entry that already carries the needed bits ends with MATCH, no further swap, and an unchanged pair.
- R5: A swap status of ACCESS ERROR (code 2) ends the request with result MEMERR (code 2) and an unchanged pair. No retry is attempted.
- R6: After a swap status OK (code 0), the result is MATCH. The pair half selected by the index input (0 = even, 1 = odd) gets bit 0 set, plus bit 1 for a store. For a small page, the other half is returned unchanged.
- R7: After a successful swap on a huge page, both halves of the pair get the same marking.
- R8: After RETRY_MAX mismatches have each led to a reload, a further mismatch ends the request with result FAULT (code 3) and an unchanged pair. RETRY_MAX+1 swaps are issued in total.
- R9: At most one of the swap request and the read request is high at a time. A pending request holds its address and data stable until it is acknowledged.
- R10: The idle output is high only when no request is in progress. A request strobe that arrives while the block is busy is ignored. Completion is a pulse that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, taken only while idle |
| in_idle | output | 1 | No request in progress |
| in_pte | input | 64 | Matched leaf entry |
| in_addr | input | PA_W | Physical address of the entry |
| in_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| in_huge | input | 1 | Entry maps a huge page |
| in_debug | input | 1 | Probe request, never modifies anything |
| in_hit | input | 1 | Lookup outcome was a match |
| in_hw_walk | input | 1 | Hardware walking enabled |
| in_idx | input | 1 | Pair half used by the access (0 even, 1 odd) |
| in_even | input | 64 | Even entry of the outgoing pair |
| in_odd | input | 64 | Odd entry of the outgoing pair |
| mem_cas | output | 1 | Compare-and-swap request |
| mem_rd | output | 1 | Reload read request |
| mem_addr | output | PA_W | Request address |
| mem_cmp | output | 64 | Expected memory value |
| mem_swp | output | 64 | Value written on equality |
| mem_ack | input | 1 | Request acknowledge, one cycle |
| mem_status | input | 2 | 0 OK, 1 mismatch, 2 access error |
| mem_rdata | input | 64 | Read data for the reload |
| out_done | output | 1 | Completion pulse |
| out_res | output | 2 | 0 MATCH, 1 NOMATCH, 2 MEMERR, 3 FAULT |
| out_even | output | 64 | Final even entry |
| out_odd | output | 64 | Final odd entry |

## Verification
The checker assumes that the memory side raises its acknowledge for a single cycle, only while a request is pending, and always with one of the three defined status codes. The checker also assumes that a new request strobe matters only while idle. The bench memory model keeps to these rules: it answers each request after a fixed wait, drops the acknowledge on the following cycle, and produces only OK, mismatch or access error. The model simulates contention by changing its stored word when it reports an injected mismatch. A reload therefore returns a different entry, just as a concurrent writer would leave it.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

    localparam int ENT_W = 64;
    localparam int A_POS = 0;
    localparam int D_POS = 1;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        MST_OK       = 2'd0,
        MST_MISMATCH = 2'd1,
        MST_ACCERR   = 2'd2
    } mst_e;

    typedef enum logic [1:0] {
        RES_MATCH   = 2'd0,
        RES_NOMATCH = 2'd1,
        RES_MEMERR  = 2'd2,
        RES_FAULT   = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_CAS   = 2'd2,
        ST_READ  = 2'd3
    } st_e;

    typedef struct packed {
        logic [ENT_W-1:0] odd;
        logic [ENT_W-1:0] even;
    } pair_t;

    function automatic logic [ENT_W-1:0] mark_bits(input logic store);
        logic [ENT_W-1:0] m;
        m        = '0;
        m[A_POS] = 1'b1;
        m[D_POS] = store;
        return m;
    endfunction

endpackage

// File: rtl/pte_ad_mark.sv
module pte_ad_mark
    import pte_ad_pkg::*;
(
    input  logic [ENT_W-1:0] ent,
    input  logic             store,
    output logic             need,
    output logic [ENT_W-1:0] newv
);
    always_comb begin
        need = store ? !ent[D_POS] : !ent[A_POS];
        newv = ent | mark_bits(store);
    end
endmodule

// File: rtl/pte_ad_pair.sv
module pte_ad_pair
    import pte_ad_pkg::*;
(
    input  pair_t pin,
    input  logic  idx,
    input  logic  huge,
    input  logic  store,
    output pair_t pout
);
    logic [1:0][ENT_W-1:0] halves_in;
    logic [1:0][ENT_W-1:0] halves_out;

    assign halves_in[0] = pin.even;
    assign halves_in[1] = pin.odd;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic sel;
        assign sel = huge || (idx == h[0]);
        assign halves_out[h] = sel ? (halves_in[h] | mark_bits(store)) : halves_in[h];
    end

    assign pout.even = halves_out[0];
    assign pout.odd  = halves_out[1];
endmodule

// File: rtl/pte_ad_ctrl.sv
module pte_ad_ctrl
    import pte_ad_pkg::*;
#(
    parameter int PA_W      = 48,
    parameter int RETRY_MAX = 16,
    localparam int RW       = $clog2(RETRY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ENT_W-1:0] in_pte,
    input  logic [PA_W-1:0]  in_addr,
    input  logic [1:0]       in_acc,
    input  logic             in_huge,
    input  logic             in_debug,
    input  logic             in_hit,
    input  logic             in_hw_walk,
    input  logic             in_idx,
    input  pair_t            in_pair,
    input  logic             need,
    input  logic [ENT_W-1:0] newv,
    input  pair_t            merged,
    input  logic             mem_ack,
    input  logic [1:0]       mem_status,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic [ENT_W-1:0] ent_q,
    output logic             store_q,
    output logic             huge_q,
    output logic             idx_q,
    output pair_t            pair_q,
    output logic             idle,
    output logic             mem_cas,
    output logic             mem_rd,
    output logic [PA_W-1:0]  mem_addr,
    output logic [ENT_W-1:0] mem_cmp,
    output logic [ENT_W-1:0] mem_swp,
    output logic             done,
    output res_e             res,
    output pair_t            out_pair
);
    st_e              st;
    logic [PA_W-1:0]  addr_q;
    logic [ENT_W-1:0] swp_q;
    logic             dbg_q, hit_q, hw_q;
    logic [RW-1:0]    rcnt;

    assign idle     = (st == ST_IDLE);
    assign mem_cas  = (st == ST_CAS);
    assign mem_rd   = (st == ST_READ);
    assign mem_addr = addr_q;
    assign mem_cmp  = ent_q;
    assign mem_swp  = swp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ent_q    <= '0;
            addr_q   <= '0;
            swp_q    <= '0;
            store_q  <= 1'b0;
            huge_q   <= 1'b0;
            idx_q    <= 1'b0;
            dbg_q    <= 1'b0;
            hit_q    <= 1'b0;
            hw_q     <= 1'b0;
            pair_q   <= '0;
            rcnt     <= '0;
            done     <= 1'b0;
            res      <= RES_MATCH;
            out_pair <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        ent_q   <= in_pte;
                        addr_q  <= in_addr;
                        store_q <= (in_acc == ACC_STORE);
                        huge_q  <= in_huge;
                        idx_q   <= in_idx;
                        dbg_q   <= in_debug;
                        hit_q   <= in_hit;
                        hw_q    <= in_hw_walk;
                        pair_q  <= in_pair;
                        rcnt    <= '0;
                        st      <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (dbg_q || !hit_q || !hw_q) begin
                        done     <= 1'b1;
                        res      <= hit_q ? RES_MATCH : RES_NOMATCH;
                        out_pair <= pair_q;
                        st       <= ST_IDLE;
                    end else if (!need) begin
                        done     <= 1'b1;
                        res      <= RES_MATCH;
                        out_pair <= pair_q;
                        st       <= ST_IDLE;
                    end else begin
                        swp_q <= newv;
                        st    <= ST_CAS;
                    end
                end
                ST_CAS: begin
                    if (mem_ack) begin
                        if (mem_status == MST_OK) begin
                            done     <= 1'b1;
                            res      <= RES_MATCH;
                            out_pair <= merged;
                            st       <= ST_IDLE;
                        end else if (mem_status == MST_MISMATCH) begin
                            if (rcnt == RW'(RETRY_MAX)) begin
                                done     <= 1'b1;
                                res      <= RES_FAULT;
                                out_pair <= pair_q;
                                st       <= ST_IDLE;
                            end else begin
                                rcnt <= rcnt + 1'b1;
                                st   <= ST_READ;
                            end
                        end else begin
                            done     <= 1'b1;
                            res      <= RES_MEMERR;
                            out_pair <= pair_q;
                            st       <= ST_IDLE;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        ent_q <= mem_rdata;
                        st    <= ST_CHECK;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
    import pte_ad_pkg::*;
#(
    parameter int PA_W      = 48,
    parameter int RETRY_MAX = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_idle,
    input  logic [63:0]      in_pte,
    input  logic [PA_W-1:0]  in_addr,
    input  logic [1:0]       in_acc,
    input  logic             in_huge,
    input  logic             in_debug,
    input  logic             in_hit,
    input  logic             in_hw_walk,
    input  logic             in_idx,
    input  logic [63:0]      in_even,
    input  logic [63:0]      in_odd,
    output logic             mem_cas,
    output logic             mem_rd,
    output logic [PA_W-1:0]  mem_addr,
    output logic [63:0]      mem_cmp,
    output logic [63:0]      mem_swp,
    input  logic             mem_ack,
    input  logic [1:0]       mem_status,
    input  logic [63:0]      mem_rdata,
    output logic             out_done,
    output logic [1:0]       out_res,
    output logic [63:0]      out_even,
    output logic [63:0]      out_odd
);
    pair_t            in_pair, pair_q, merged, out_pair;
    logic [ENT_W-1:0] ent_q, newv;
    logic             need, store_q, huge_q, idx_q;
    res_e             res;

    assign in_pair.even = in_even;
    assign in_pair.odd  = in_odd;

    pte_ad_mark u_mark (
        .ent   (ent_q),
        .store (store_q),
        .need  (need),
        .newv  (newv)
    );

    pte_ad_pair u_pair (
        .pin   (pair_q),
        .idx   (idx_q),
        .huge  (huge_q),
        .store (store_q),
        .pout  (merged)
    );

    pte_ad_ctrl #(.PA_W(PA_W), .RETRY_MAX(RETRY_MAX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_pte     (in_pte),
        .in_addr    (in_addr),
        .in_acc     (in_acc),
        .in_huge    (in_huge),
        .in_debug   (in_debug),
        .in_hit     (in_hit),
        .in_hw_walk (in_hw_walk),
        .in_idx     (in_idx),
        .in_pair    (in_pair),
        .need       (need),
        .newv       (newv),
        .merged     (merged),
        .mem_ack    (mem_ack),
        .mem_status (mem_status),
        .mem_rdata  (mem_rdata),
        .ent_q      (ent_q),
        .store_q    (store_q),
        .huge_q     (huge_q),
        .idx_q      (idx_q),
        .pair_q     (pair_q),
        .idle       (in_idle),
        .mem_cas    (mem_cas),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_cmp    (mem_cmp),
        .mem_swp    (mem_swp),
        .done       (out_done),
        .res        (res),
        .out_pair   (out_pair)
    );

    assign out_res  = res;
    assign out_even = out_pair.even;
    assign out_odd  = out_pair.odd;
endmodule

// File: rtl/pte_ad_updater_chk.sv
module pte_ad_updater_chk
    import pte_ad_pkg::*;
#(
    parameter int PA_W = 48
) (
    input logic            clk,
    input logic            rst,
    input logic            in_idle,
    input logic            mem_cas,
    input logic            mem_rd,
    input logic            mem_ack,
    input logic [1:0]      mem_status,
    input logic [PA_W-1:0] mem_addr,
    input logic [63:0]     mem_cmp,
    input logic [63:0]     mem_swp,
    input logic            out_done,
    input logic [1:0]      out_res
);
    a_r9_one_req: assert property (@(posedge clk) disable iff (rst)
        !(mem_cas && mem_rd));

    a_r9_cas_hold: assert property (@(posedge clk) disable iff (rst)
        mem_cas && !mem_ack |=> mem_cas && $stable(mem_addr) && $stable(mem_cmp) && $stable(mem_swp));

    a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
        mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));

    a_r3_swap_adds_bits: assert property (@(posedge clk) disable iff (rst)
        mem_cas |-> ((mem_swp & mem_cmp) == mem_cmp) && mem_swp[A_POS] && (mem_swp != mem_cmp));

    a_r4_reload_follows: assert property (@(posedge clk) disable iff (rst)
        mem_cas && mem_ack && mem_status == MST_MISMATCH |=> mem_rd || (out_done && out_res == RES_FAULT));

    a_r5_accerr_ends: assert property (@(posedge clk) disable iff (rst)
        mem_cas && mem_ack && mem_status == MST_ACCERR |=> out_done && out_res == RES_MEMERR);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> !mem_cas && !mem_rd);
endmodule

bind pte_ad_updater pte_ad_updater_chk #(.PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_idle    (in_idle),
    .mem_cas    (mem_cas),
    .mem_rd     (mem_rd),
    .mem_ack    (mem_ack),
    .mem_status (mem_status),
    .mem_addr   (mem_addr),
    .mem_cmp    (mem_cmp),
    .mem_swp    (mem_swp),
    .out_done   (out_done),
    .out_res    (out_res)
);

// File: tb/pte_ad_updater_bench.sv
module pte_ad_updater_bench;
    localparam int PA_W = 48;
    localparam int RMAX = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_idle;
    logic [63:0]     in_pte = '0;
    logic [PA_W-1:0] in_addr = '0;
    logic [1:0]      in_acc = '0;
    logic            in_huge = 1'b0, in_debug = 1'b0, in_hit = 1'b0, in_hw_walk = 1'b0, in_idx = 1'b0;
    logic [63:0]     in_even = '0, in_odd = '0;
    logic            mem_cas, mem_rd;
    logic [PA_W-1:0] mem_addr;
    logic [63:0]     mem_cmp, mem_swp;
    logic            mem_ack = 1'b0;
    logic [1:0]      mem_status = '0;
    logic [63:0]     mem_rdata = '0;
    logic            out_done;
    logic [1:0]      out_res;
    logic [63:0]     out_even, out_odd;

    always #4 clk = ~clk;

    pte_ad_updater #(.PA_W(PA_W), .RETRY_MAX(RMAX)) u_pte_ad_updater (.*);

    int errors = 0, checks = 0;
    logic finished = 1'b0;

    logic [63:0]     mem_word = '0;
    logic [63:0]     inj_or = '0;
    int              inj_mis = 0;
    logic            rom = 1'b0;
    int              ncas = 0, nrd = 0;
    logic [63:0]     last_cmp = '0, last_swp = '0;
    logic [PA_W-1:0] last_addr = '0;
    logic [1:0]      got_res;
    logic [63:0]     got_even, got_odd;
    logic            got_done;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // memory responder: fixed wait of two cycles, one-cycle acknowledge
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_cas || mem_rd) begin
                wcnt++;
                if (wcnt >= 2) begin
                    wcnt = 0;
                    last_addr = mem_addr;
                    if (mem_cas) begin
                        ncas++;
                        last_cmp = mem_cmp;
                        last_swp = mem_swp;
                        if (rom) mem_status = 2'd2;
                        else if (inj_mis > 0) begin
                            inj_mis--;
                            mem_word = mem_word | inj_or;
                            mem_status = 2'd1;
                        end else if (mem_word == mem_cmp) begin
                            mem_word = mem_swp;
                            mem_status = 2'd0;
                        end else mem_status = 2'd1;
                    end else begin
                        nrd++;
                        mem_rdata = mem_word;
                        mem_status = 2'd0;
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic issue(input logic [63:0] pte, input logic [1:0] acc, input logic huge, input logic idx,
                         input logic dbg, input logic hit, input logic hw,
                         input logic [63:0] ev, input logic [63:0] od);
        @(negedge clk);
        in_valid = 1'b1; in_pte = pte; in_acc = acc; in_huge = huge; in_idx = idx;
        in_debug = dbg; in_hit = hit; in_hw_walk = hw; in_even = ev; in_odd = od;
        in_addr = 48'h0000_8000_1238 ^ {32'd0, pte[15:0]};
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        got_done = 1'b0;
        for (int k = 0; k < 400 && !got_done; k++) begin
            if (out_done) begin
                got_done = 1'b1;
                got_res = out_res; got_even = out_even; got_odd = out_odd;
            end else @(negedge clk);
        end
        chk(got_done, "R10 completion seen", {63'd0, got_done}, 64'd1);
    endtask

    task automatic prep(input logic [63:0] pte);
        ncas = 0; nrd = 0; mem_word = pte; rom = 1'b0; inj_mis = 0; inj_or = '0;
    endtask

    initial begin
        logic [63:0] mark, ev, od, pte, xe, xo;
        logic        st, need, upd;
        logic [1:0]  xres;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_idle && !out_done && !mem_cas && !mem_rd, "R10 reset state",
            {60'd0, in_idle, out_done, mem_cas, mem_rd}, 64'h8);

        // sweep: access kind x A x D x huge x idx x probe x hit x walk
        for (int acc = 0; acc < 3; acc++)
        for (int ad = 0; ad < 4; ad++)
        for (int hg = 0; hg < 2; hg++)
        for (int ix = 0; ix < 2; ix++)
        for (int fl = 0; fl < 8; fl++) begin
            pte  = 64'h0123_4560_0000_0A00 | {56'd0, 4'(acc), 2'd0, 2'(ad)} | (64'(fl) << 20);
            od   = 64'h00FF_0000_0000_5000 | (64'(ad) << 8);
            ev   = ix[0] ? 64'h00EE_0000_0000_7000 : pte;
            if (ix[0]) od = pte;
            st   = (acc == 1);
            mark = {62'd0, st, 1'b1};
            need = st ? !pte[1] : !pte[0];
            upd  = !fl[0] && fl[1] && fl[2] && need;
            xres = fl[1] ? 2'd0 : 2'd1;
            xe = ev; xo = od;
            if (upd) begin
                if (hg[0] || !ix[0]) xe = ev | mark;
                if (hg[0] ||  ix[0]) xo = od | mark;
            end
            prep(pte);
            issue(pte, 2'(acc), hg[0], ix[0], fl[0], fl[1], fl[2], ev, od);
            wait_done();
            if (!upd && fl[0]) chk(ncas == 0 && got_even == ev && got_odd == od, "R2 probe untouched", got_even, ev);
            else if (!upd && (!fl[1] || !fl[2])) chk(ncas == 0 && got_res == xres, "R2 no walk or miss", 64'(got_res), 64'(xres));
            else if (!upd) chk(ncas == 0 && got_res == 2'd0, "R1 bits present skip", 64'(ncas), 64'd0);
            else begin
                chk(ncas == 1 && last_cmp == pte && last_swp == (pte | mark), "R3 swap values", last_swp, pte | mark);
                chk(last_addr == in_addr, "R3 swap address", 64'(last_addr), 64'(in_addr));
            end
            chk(got_res == xres, "R1 result code", 64'(got_res), 64'(xres));
            chk(got_even == xe, hg[0] ? "R7 even half" : "R6 even half", got_even, xe);
            chk(got_odd == xo, hg[0] ? "R7 odd half" : "R6 odd half", got_odd, xo);
        end

        // R4: contention by an unrelated bit change, then a successful retry
        pte = 64'h0000_0012_3450_0000;
        prep(pte); inj_mis = 1; inj_or = 64'h0000_0100_0000_0000;
        issue(pte, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, pte, 64'h40);
        wait_done();
        chk(ncas == 2 && nrd == 1, "R4 reload and retry counts", 64'(ncas), 64'd2);
        chk(last_cmp == (pte | inj_or) && last_swp == (pte | inj_or | 64'h3), "R4 retry uses reloaded entry", last_swp, pte | inj_or | 64'h3);
        chk(got_res == 2'd0 && got_even == (pte | 64'h3) && got_odd == 64'h40, "R4 pair after retry", got_even, pte | 64'h3);

        // R4: concurrent writer already set accessed; reload ends with no swap
        pte = 64'h0000_0077_0000_0000;
        prep(pte); inj_mis = 1; inj_or = 64'h1;
        issue(pte, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h80, pte);
        wait_done();
        chk(ncas == 1 && nrd == 1 && got_res == 2'd0, "R4 reload already marked", 64'(ncas), 64'd1);
        chk(got_even == 64'h80 && got_odd == pte, "R4 pair unchanged after marked reload", got_odd, pte);

        // R5: access error, no retry
        pte = 64'h0000_0055_0000_0000;
        prep(pte); rom = 1'b1;
        issue(pte, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, pte, 64'h90);
        wait_done();
        chk(ncas == 1 && nrd == 0, "R5 no retry", 64'(ncas), 64'd1);
        chk(got_res == 2'd2 && got_even == pte && got_odd == 64'h90, "R5 memerr and pair", 64'(got_res), 64'd2);

        // R8: endless contention
        pte = 64'h0000_0066_0000_0000;
        prep(pte); inj_mis = 100; inj_or = 64'h0000_0200_0000_0000;
        issue(pte, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'hA0, pte);
        wait_done();
        chk(ncas == RMAX + 1 && nrd == RMAX, "R8 swap count", 64'(ncas), 64'(RMAX + 1));
        chk(got_res == 2'd3 && got_odd == pte && got_even == 64'hA0, "R8 fault result", 64'(got_res), 64'd3);

        // R10: strobe while busy is ignored; pulse is one cycle
        pte = 64'h0000_0033_0000_0000;
        prep(pte);
        issue(pte, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, pte, 64'hB0);
        chk(!in_idle, "R10 busy flag", {63'd0, in_idle}, 64'd0);
        in_valid = 1'b1; in_pte = 64'h0000_0044_0000_0002; in_acc = 2'd1;
        @(negedge clk);
        in_valid = 1'b0;
        wait_done();
        chk(ncas == 1 && last_cmp == pte, "R10 busy strobe ignored", last_cmp, pte);
        chk(got_even == (pte | 64'h1) && got_odd == 64'hB0, "R10 first request result", got_even, pte | 64'h1);
        @(negedge clk);
        chk(!out_done && in_idle, "R10 one-cycle pulse", {63'd0, out_done}, 64'd0);
        repeat (4) @(negedge clk);
        chk(ncas == 1 && !out_done, "R10 no second request", 64'(ncas), 64'd1);

        summary();
    end
endmodule